// File: doc/BRIEF.md
# Configuration Header Target with Base Address Decode

This block is the target-side configuration header of a small add-in device. System software reaches it through configuration cycles that carry the device's select input. It reads the identification word, programs a base address into each of two base address registers, and then turns on memory or I/O space in the command register. Until that is done the device claims no memory or I/O cycle, so its ranges are never fixed by hardware.

The first base register describes a 4 KiB memory window. The second describes a 256-byte I/O window. The low bits of each base register are tied, so that writing all ones and reading back gives the size mask. Once a space is enabled, each incoming address is compared with the programmed base above the size boundary, and the matching hit output goes high in the same cycle.

Configuration reads return data one clock after the strobe, together with a one-cycle valid. Writes take effect at the clock edge and honour per-byte enables.

Top module: `cfg_hdr_target`

## Requirements
- R1: After reset the command register, both base registers and both hit outputs are zero, apart from the I/O indicator bit 0 of the I/O base register, which reads 1.
- R2: A read of dword index 0 returns {device ID, vendor ID}, with the vendor ID in bits 15:0. The vendor ID is never 0xFFFF, and writes to this index change nothing.
- R3: A configuration read or write with the select input low has no effect: it produces no read valid and changes no register.
- R4: A selected read strobe at a clock edge gives cfg_rvalid high for exactly the next cycle, with the data on cfg_rdata. cfg_rvalid is never high at any other time.
- R5: Command register (index 1): bit 0 enables I/O space and bit 1 enables memory space. Bits 31:2 read as zero and ignore writes.
- R6: Memory base register (index 4): bits 11:0 always read zero, with bit 0 = 0 marking memory space. Writing 0xFFFFFFFF reads back 0xFFFFF000.
- R7: I/O base register (index 5): bits 7:1 read zero and bit 0 reads 1. Writing 0xFFFFFFFF reads back 0xFFFFFF01.
- R8: A write updates only the bytes whose byte-enable bit is set. cfg_be[n] covers wdata bits 8n+7:8n.
- R9: mem_hit is high exactly when bus_mem is high, the memory enable is set, and bus_addr[31:12] equals memory base bits 31:12.
- R10: io_hit is high exactly when bus_io is high, the I/O enable is set, and bus_addr[31:8] equals I/O base bits 31:8.
- R11: Indices that have no register read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel | input | 1 | Device select for configuration cycles |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_idx | input | 6 | Dword index into configuration space |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a selected read |
| bus_addr | input | 32 | Address of the current memory or I/O cycle |
| bus_mem | input | 1 | Current cycle is a memory cycle |
| bus_io | input | 1 | Current cycle is an I/O cycle |
| mem_hit | output | 1 | Memory cycle falls in the programmed memory window |
| io_hit | output | 1 | I/O cycle falls in the programmed I/O window |

## Verification
Decode is tried at the first and last byte of each programmed window and one byte beyond each edge, which separates a correct size boundary from one that is off by a bit. The same addresses are offered with the wrong cycle type and under each single-space enable setting, which tells the enable gating apart from the type gating. On the register side, sizing writes of all ones, partial byte-enable writes, writes to read-only and unimplemented indices, and unselected accesses each have one observable outcome that only the correct masking produces.

// File: rtl/cfg_pkg.sv
// Package: shared constants for the configuration header target.
// Assumes dword-indexed configuration space of 64 entries.
package cfg_pkg;
    localparam int CFG_IDX_W = 6;
    localparam logic [CFG_IDX_W-1:0] IDX_IDENT = 6'd0;
    localparam logic [CFG_IDX_W-1:0] IDX_CMD   = 6'd1;
    localparam logic [CFG_IDX_W-1:0] IDX_BAR0  = 6'd4;
    localparam int NUM_BARS = 2;

    // Byte-wise merge of new data into an old word under byte enables.
    function automatic logic [31:0] merge_be(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/cfg_bar_reg.sv
// Module: one base address register with size masking.
// Bits below SIZE_LOG2 are tied: bit 0 reads IS_IO, the rest read zero.
// Assumes wr_en is already qualified by select, write strobe and index.
module cfg_bar_reg #(
    parameter int SIZE_LOG2 = 12,
    parameter bit IS_IO     = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] bar_val
);
    import cfg_pkg::*;

    localparam logic [31:0] ADDR_MASK = ~((32'd1 << SIZE_LOG2) - 32'd1);
    localparam logic [31:0] LOW_BITS  = {31'd0, IS_IO};

    logic [31:0] bar_q;

    // Store the merged write, forcing the tied low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bar_q <= LOW_BITS;
        else if (wr_en)
            bar_q <= (merge_be(bar_q, wdata, be) & ADDR_MASK) | LOW_BITS;
    end

    assign bar_val = bar_q;
endmodule

// File: rtl/cfg_bar_match.sv
// Module: window comparator for one base address register.
// Compares the address bits above the window size. Assumes cycle_ok
// already combines the cycle type with the command-register enable.
module cfg_bar_match #(
    parameter int SIZE_LOG2 = 12
) (
    input  logic [31:0] addr,
    input  logic [31:0] bar_val,
    input  logic        cycle_ok,
    output logic        hit
);
    localparam logic [31:0] ADDR_MASK = ~((32'd1 << SIZE_LOG2) - 32'd1);

    // Claim the cycle when the masked address matches the base.
    always_comb hit = cycle_ok && ((addr & ADDR_MASK) == (bar_val & ADDR_MASK));
endmodule

// File: rtl/cfg_hdr_target.sv
// Module: configuration header target with memory and I/O window decode.
// Holds identity, command and two base registers; answers selected
// configuration cycles with one-cycle read latency; decodes bus cycles
// combinationally against the programmed windows.
module cfg_hdr_target #(
    parameter logic [15:0] VENDOR_ID     = 16'h1B7E,
    parameter logic [15:0] DEVICE_ID     = 16'h0042,
    parameter int          MEM_SIZE_LOG2 = 12,
    parameter int          IO_SIZE_LOG2  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_sel,
    input  logic        cfg_rd,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_dw_idx,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        cfg_rvalid,
    input  logic [31:0] bus_addr,
    input  logic        bus_mem,
    input  logic        bus_io,
    output logic        mem_hit,
    output logic        io_hit
);
    import cfg_pkg::*;

    logic        sel_wr, sel_rd;
    logic [1:0]  cmd_q;      // [0] I/O enable, [1] memory enable
    logic [31:0] bar_val [NUM_BARS];
    logic        bar_hit [NUM_BARS];
    logic        cyc_ok  [NUM_BARS];
    logic [31:0] rd_mux;

    // Qualify strobes with the device select.
    always_comb begin
        sel_wr = cfg_sel && cfg_wr;
        sel_rd = cfg_sel && cfg_rd;
    end

    // Command register: only the two space enables are writable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= 2'b00;
        else if (sel_wr && cfg_dw_idx == IDX_CMD && cfg_be[0])
            cmd_q <= cfg_wdata[1:0];
    end

    // Cycle-type gating: BAR0 answers memory cycles, BAR1 answers I/O cycles.
    always_comb begin
        cyc_ok[0] = bus_mem && cmd_q[1];
        cyc_ok[1] = bus_io  && cmd_q[0];
    end

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        localparam int SL   = (g == 0) ? MEM_SIZE_LOG2 : IO_SIZE_LOG2;
        localparam bit ISIO = (g == 1);
        localparam logic [5:0] MY_IDX = IDX_BAR0 + 6'(g);

        cfg_bar_reg #(.SIZE_LOG2(SL), .IS_IO(ISIO)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (sel_wr && cfg_dw_idx == MY_IDX),
            .be      (cfg_be),
            .wdata   (cfg_wdata),
            .bar_val (bar_val[g])
        );

        cfg_bar_match #(.SIZE_LOG2(SL)) u_match (
            .addr     (bus_addr),
            .bar_val  (bar_val[g]),
            .cycle_ok (cyc_ok[g]),
            .hit      (bar_hit[g])
        );
    end

    assign mem_hit = bar_hit[0];
    assign io_hit  = bar_hit[1];

    // Read multiplexer over the implemented indices.
    always_comb begin
        case (cfg_dw_idx)
            IDX_IDENT:       rd_mux = {DEVICE_ID, VENDOR_ID};
            IDX_CMD:         rd_mux = {30'd0, cmd_q};
            IDX_BAR0:        rd_mux = bar_val[0];
            IDX_BAR0 + 6'd1: rd_mux = bar_val[1];
            default:         rd_mux = 32'd0;
        endcase
    end

    // Register read data and its one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rdata  <= 32'd0;
            cfg_rvalid <= 1'b0;
        end else begin
            cfg_rdata  <= sel_rd ? rd_mux : 32'd0;
            cfg_rvalid <= sel_rd;
        end
    end
endmodule

// File: rtl/cfg_hdr_target_chk.sv
// Module: assertion checker for cfg_hdr_target, attached by bind.
// Observes ports only; assumes the same parameters as the target.
module cfg_hdr_target_chk #(
    parameter logic [15:0] VENDOR_ID     = 16'h1B7E,
    parameter logic [15:0] DEVICE_ID     = 16'h0042,
    parameter int          MEM_SIZE_LOG2 = 12,
    parameter int          IO_SIZE_LOG2  = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_sel,
    input logic        cfg_rd,
    input logic [5:0]  cfg_dw_idx,
    input logic [31:0] cfg_rdata,
    input logic        cfg_rvalid,
    input logic        bus_mem,
    input logic        bus_io,
    input logic        mem_hit,
    input logic        io_hit
);
    localparam logic [31:0] MEM_LOW = (32'd1 << MEM_SIZE_LOG2) - 32'd1;
    localparam logic [31:0] IO_LOW  = (32'd1 << IO_SIZE_LOG2) - 32'd1;

    // R4
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && cfg_rd) |=> cfg_rvalid);

    // R3
    sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sel |=> !cfg_rvalid);

    // R2
    ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rvalid && $past(cfg_dw_idx) == 6'd0) |-> cfg_rdata == {DEVICE_ID, VENDOR_ID});

    // R5
    cmd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rvalid && $past(cfg_dw_idx) == 6'd1) |-> cfg_rdata[31:2] == 30'd0);

    // R6
    mem_bar_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rvalid && $past(cfg_dw_idx) == 6'd4) |-> (cfg_rdata & MEM_LOW) == 32'd0);

    // R7
    io_bar_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rvalid && $past(cfg_dw_idx) == 6'd5) |-> (cfg_rdata & IO_LOW) == 32'd1);

    // R9
    mem_hit_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> bus_mem);

    // R10
    io_hit_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> bus_io);
endmodule

bind cfg_hdr_target cfg_hdr_target_chk #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .MEM_SIZE_LOG2(MEM_SIZE_LOG2), .IO_SIZE_LOG2(IO_SIZE_LOG2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_rd(cfg_rd),
    .cfg_dw_idx(cfg_dw_idx), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .bus_mem(bus_mem), .bus_io(bus_io), .mem_hit(mem_hit), .io_hit(io_hit)
);

// File: tb/cfg_hdr_target_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard for cfg_hdr_target. Read tasks queue expected words;
// a monitor pops them when cfg_rvalid shows. Decode is checked directly.
module cfg_hdr_target_bench;
    localparam logic [15:0] VID = 16'h1B7E;
    localparam logic [15:0] DID = 16'h0042;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel = 1'b0, cfg_rd = 1'b0, cfg_wr = 1'b0;
    logic [5:0]  cfg_dw_idx = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_rvalid;
    logic [31:0] bus_addr = '0;
    logic        bus_mem = 1'b0, bus_io = 1'b0;
    logic        mem_hit, io_hit;

    int chk_cnt  = 0;
    int fail_cnt = 0;
    logic [31:0] exp_q [$];
    string       req_q [$];

    always #2.5 clk = ~clk;

    cfg_hdr_target u_cfg_hdr_target (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_rd(cfg_rd),
        .cfg_wr(cfg_wr), .cfg_dw_idx(cfg_dw_idx), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
        .bus_addr(bus_addr), .bus_mem(bus_mem), .bus_io(bus_io),
        .mem_hit(mem_hit), .io_hit(io_hit)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        chk_cnt++;
        if (got !== exp) begin
            fail_cnt++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Monitor: every read valid must match the oldest expectation (R4).
    always @(negedge clk) begin
        if (rst_n && cfg_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                check(r, cfg_rdata, e);
            end
        end
    end

    task automatic cfg_write(input logic [5:0] idx, input logic [31:0] d,
                             input logic [3:0] be, input logic sel);
        @(negedge clk);
        cfg_sel = sel; cfg_wr = 1'b1; cfg_dw_idx = idx; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_sel = 1'b0; cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_read(input logic [5:0] idx, input logic [31:0] exp, input string req);
        @(negedge clk);
        exp_q.push_back(exp); req_q.push_back(req);
        cfg_sel = 1'b1; cfg_rd = 1'b1; cfg_dw_idx = idx;
        @(negedge clk);
        cfg_sel = 1'b0; cfg_rd = 1'b0;
    endtask

    task automatic cfg_read_unsel(input logic [5:0] idx);
        @(negedge clk);
        cfg_sel = 1'b0; cfg_rd = 1'b1; cfg_dw_idx = idx;
        @(negedge clk);
        cfg_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic probe(input logic [31:0] a, input logic m, input logic i,
                         input logic exp_m, input logic exp_i, input string req);
        @(negedge clk);
        bus_addr = a; bus_mem = m; bus_io = i;
        #1;
        check({req, " mem_hit"}, {31'd0, mem_hit}, {31'd0, exp_m});
        check({req, " io_hit"},  {31'd0, io_hit},  {31'd0, exp_i});
        bus_mem = 1'b0; bus_io = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        check("watchdog", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state; nothing decodes before enables are set
        probe(32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        probe(32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        cfg_read(6'd1, 32'h0, "R1 cmd");
        cfg_read(6'd4, 32'h0, "R1 bar0");
        cfg_read(6'd5, 32'h1, "R1 bar1");
        // R2: identity, read-only
        cfg_read(6'd0, {DID, VID}, "R2 ident");
        cfg_write(6'd0, 32'hFFFF_FFFF, 4'hF, 1'b1);
        cfg_read(6'd0, {DID, VID}, "R2 ident after write");
        // R3: unselected accesses ignored
        cfg_read_unsel(6'd0);
        cfg_write(6'd1, 32'h3, 4'hF, 1'b0);
        cfg_read(6'd1, 32'h0, "R3 unselected write");
        // R6/R7: sizing
        cfg_write(6'd4, 32'hFFFF_FFFF, 4'hF, 1'b1);
        cfg_read(6'd4, 32'hFFFF_F000, "R6 size mask");
        cfg_write(6'd5, 32'hFFFF_FFFF, 4'hF, 1'b1);
        cfg_read(6'd5, 32'hFFFF_FF01, "R7 size mask");
        // R5: command register
        cfg_write(6'd1, 32'hFFFF_FFFF, 4'hF, 1'b1);
        cfg_read(6'd1, 32'h3, "R5 cmd bits");
        // R8: byte enables
        cfg_write(6'd4, 32'h1234_5678, 4'b1000, 1'b1);
        cfg_read(6'd4, 32'h12FF_F000, "R8 byte3");
        cfg_write(6'd4, 32'h00AB_0000, 4'b0100, 1'b1);
        cfg_read(6'd4, 32'h12AB_F000, "R8 byte2");
        // R11: unimplemented indices
        cfg_write(6'd7, 32'hDEAD_BEEF, 4'hF, 1'b1);
        cfg_read(6'd7, 32'h0, "R11 idx7");
        cfg_read(6'd2, 32'h0, "R11 idx2");
        // Program windows
        cfg_write(6'd4, 32'h4000_0000, 4'hF, 1'b1);
        cfg_write(6'd5, 32'h0000_C100, 4'hF, 1'b1);
        cfg_read(6'd5, 32'h0000_C101, "R7 programmed");
        // R9: memory window edges and type
        probe(32'h4000_0000, 1'b1, 1'b0, 1'b1, 1'b0, "R9 first");
        probe(32'h4000_0FFF, 1'b1, 1'b0, 1'b1, 1'b0, "R9 last");
        probe(32'h4000_1000, 1'b1, 1'b0, 1'b0, 1'b0, "R9 above");
        probe(32'h3FFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, "R9 below");
        probe(32'h4000_0010, 1'b0, 1'b1, 1'b0, 1'b0, "R9 io type");
        // R10: I/O window edges and type
        probe(32'h0000_C100, 1'b0, 1'b1, 1'b0, 1'b1, "R10 first");
        probe(32'h0000_C1FF, 1'b0, 1'b1, 1'b0, 1'b1, "R10 last");
        probe(32'h0000_C200, 1'b0, 1'b1, 1'b0, 1'b0, "R10 above");
        probe(32'h0000_C0FF, 1'b0, 1'b1, 1'b0, 1'b0, "R10 below");
        probe(32'h0000_C110, 1'b1, 1'b0, 1'b0, 1'b0, "R10 mem type");
        // R9/R10: enables individually
        cfg_write(6'd1, 32'h1, 4'h1, 1'b1);
        probe(32'h4000_0010, 1'b1, 1'b0, 1'b0, 1'b0, "R9 mem disabled");
        probe(32'h0000_C110, 1'b0, 1'b1, 1'b0, 1'b1, "R10 io enabled");
        cfg_write(6'd1, 32'h2, 4'h1, 1'b1);
        probe(32'h4000_0010, 1'b1, 1'b0, 1'b1, 1'b0, "R9 mem enabled");
        probe(32'h0000_C110, 1'b0, 1'b1, 1'b0, 1'b0, "R10 io disabled");
        repeat (4) @(negedge clk);
        // R4: every queued read was answered
        check("R4 pending reads", exp_q.size(), 32'd0);
        $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
        $finish;
    end
endmodule